// File: doc/BRIEF.md
# I2C Register File Slave

This block lets an external I2C bus master read and write a small bank of eight byte-wide registers. The host logic sees all register contents at once on a flat parallel bus. The I2C pins are oversampled from the system clock. SCL and SDA each pass through a two-flop synchronizer and a majority-free glitch filter, and the block then detects START, repeated START and STOP conditions. The slave pulls SDA low through a single output-enable to acknowledge bytes and to send read data. The surrounding pad logic provides the open-drain behaviour.

A write transfer carries the 7-bit device address with a write direction bit, then a register pointer byte, then one data byte. A read transfer sets the pointer in the same way, then issues a repeated START and the address with the read bit. The slave then returns the byte at the stored pointer. The pointer never steps on its own, so every byte of a transfer refers to one register. A pointer that names no register is still acknowledged, but it stores nothing and reads back as zero. General call and 10-bit headers get no response.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The slave acknowledges a first byte whose upper seven bits equal DEV_ADDR (default 0x42). Any other first byte gets no acknowledge, and the slave stays off the bus until the next START. This includes a 10-bit header 0b11110xx.
- R2: A first byte of 0x00 (general call) is not acknowledged and changes neither a register nor the stored pointer.
- R3: After reset all eight registers read 0x00 and SDA is released. Register i appears on regs_o bits [8i+7:8i].
- R4: The sequence START, address with direction bit 0, pointer byte, data byte, STOP gets an acknowledge for each of the three bytes and stores the data byte in the register the pointer names.
- R5: After a pointer write, a repeated START and the address with direction bit 1, the slave acknowledges and returns the addressed register's byte MSB first.
- R6: After the master answers a read byte with NACK, the slave releases SDA. After the following STOP it is idle, with SDA released.
- R7: The pointer never increments. A second data byte in one write lands in the same register. If the master acknowledges a read byte, the same register's byte is sent again.
- R8: START and repeated START restart address matching but keep the stored pointer. A read issued directly after START, with no pointer byte, returns the register at the pointer left by an earlier transfer.
- R9: A pointer of 8 or more is acknowledged. Data written to it is discarded, and a read from it returns 0x00.
- R10: The slave changes SDA only while SCL is low. It samples SDA when SCL rises, so a bit it sends is stable for the whole SCL high phase.
- R11: A pulse on SCL or SDA shorter than FILT_LEN system clocks (default 3) is filtered out. A SCL pulse adds no bit, and a SDA pulse during SCL high creates no START or STOP.
- R12: With a 125 MHz system clock, transfers complete correctly at 400 kbit/s (312 clocks per bit) and at 100 kbit/s (1250 clocks per bit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge or a 0 data bit) |
| regs_o | output | NUM_REGS*8 | Contents of all registers, register i in bits [8i+7:8i] |

## Verification
The assertions assume a well-behaved master. It moves SDA only while SCL is low, except when it deliberately forms START or STOP. It never signals START or STOP while the slave is holding SDA low. Each bus phase lasts far longer than the filter and synchronizer delay of about seven clocks. The bench models the line as the wired-AND of the master's drive and the slave's output enable. It changes SDA a quarter bit after SCL falls and raises SCL a quarter bit later. The only exceptions are short deliberate glitches, which are kept below the filter length so that the filtered lines still obey these rules.

// File: rtl/i2c_rf_pkg.sv
// Shared definitions for the I2C register file slave.
// Assumes byte-oriented transfers of fixed width on the bus.
package i2c_rf_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    // Protocol phases of the slave
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } rf_state_e;

endpackage

// File: rtl/i2c_rf_sync.sv
// Brings asynchronous bus lines into the clock domain and removes short pulses.
// Each line gets a two-flop synchronizer followed by a history register.
// The filtered output only moves once FILT_LEN consecutive samples agree.
// Assumes lines idle high, so all stages reset to 1.
module i2c_rf_sync #(
    parameter int LINES    = 2,
    parameter int FILT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [1:0]          meta;
        logic [FILT_LEN-1:0] hist;
        logic                filt;

        // synchronize, record recent samples, update output on agreement
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= 2'b11;
                hist <= '1;
                filt <= 1'b1;
            end else begin
                meta <= {meta[0], din[g]};
                hist <= {hist[FILT_LEN-2:0], meta[1]};
                if (&hist)
                    filt <= 1'b1;
                else if (~|hist)
                    filt <= 1'b0;
            end
        end

        assign dout[g] = filt;
    end

endmodule

// File: rtl/i2c_rf_cond.sv
// Detects SCL edges and START/STOP conditions on the filtered lines.
// START: SDA falls while SCL stays high. STOP: SDA rises while SCL stays high.
// Assumes inputs are already synchronous and glitch-free.
module i2c_rf_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    // remember previous line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign start_det = scl & scl_q & sda_q & ~sda;
    assign stop_det  = scl & scl_q & ~sda_q & sda;

endmodule

// File: rtl/i2c_rf_regs.sv
// Register bank written by the protocol engine and read by both sides.
// Only in-range indices are stored. Out-of-range reads return zero.
// Assumes at most one write per clock.
module i2c_rf_regs
    import i2c_rf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int PTR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [PTR_W-1:0]           rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [BYTE_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // store data when the engine writes this index
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && (wr_addr == PTR_W'(i)))
                regs[i] <= wr_data;
        end

        assign regs_flat[i*BYTE_W +: BYTE_W] = regs[i];

        // R9
        reg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (regs[i] != $past(regs[i])) |-> ($past(wr_en) && ($past(wr_addr) == PTR_W'(i))));
    end

    // read port with zero for unmapped indices
    always_comb begin
        if (rd_addr < PTR_W'(NUM_REGS))
            rd_data = regs[rd_addr[IDX_W-1:0]];
        else
            rd_data = '0;
    end

endmodule

// File: rtl/i2c_rf_fsm.sv
// Byte-level protocol engine of the slave.
// Shifts bits in on SCL rise and drives SDA on SCL fall.
// Generates acknowledges, holds the register pointer and issues write strobes.
// Assumes filtered lines and single-cycle edge and condition pulses.
module i2c_rf_fsm
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42,
    parameter int         PTR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    rf_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              ack_seen;

    // advance the protocol on bus events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            ack_seen <= 1'b0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
            sda_oe   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            cnt <= '0;
                            if (shreg[7:1] == DEV_ADDR && shreg[7:1] != 7'd0) begin
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_PTR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            cnt    <= '0;
                            ptr    <= PTR_W'(shreg);
                            sda_oe <= 1'b1;
                            state  <= ST_PTR_ACK;
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            cnt     <= '0;
                            wr_en   <= 1'b1;
                            wr_data <= shreg;
                            sda_oe  <= 1'b1;
                            state   <= ST_WDATA_ACK;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                cnt    <= '0;
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            ack_seen <= ~sda;
                        end else if (scl_fall) begin
                            if (ack_seen) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // R10
    sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl);

    // R2
    gencall_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && cnt == LAST_BIT && shreg == 8'h00)
        |=> (state == ST_IGNORE && !sda_oe));

    // R8
    ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (ptr == $past(ptr)));

    // R6
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && state == ST_IDLE));

    // R1
    addr_ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> ($past(shreg[7:1]) == DEV_ADDR));

endmodule

// File: rtl/i2c_regfile_slave.sv
// Top level of the I2C register file slave.
// Oversamples the bus, detects conditions, runs the protocol engine
// and holds the register bank. The pad provides the open-drain driver:
// sda_oe_o high pulls SDA low.
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42,
    parameter int         NUM_REGS = 8,
    parameter int         FILT_LEN = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    localparam int PTR_W = BYTE_W;

    logic [1:0]        filt;
    logic              scl_f;
    logic              sda_f;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;

    i2c_rf_sync #(.LINES(2), .FILT_LEN(FILT_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (filt)
    );

    assign scl_f = filt[1];
    assign sda_f = filt[0];

    i2c_rf_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_f),
        .sda      (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_rf_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_f),
        .sda      (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe_o)
    );

    i2c_rf_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (ptr),
        .wr_data  (wr_data),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .regs_flat(regs_o)
    );

endmodule

// File: tb/i2c_regfile_slave_tb.sv
// Bench: bus master model, vector table walk, then directed corner cases.
module i2c_regfile_slave_tb;

    localparam logic [6:0] DEV = 7'h42;
    localparam int Q_FAST = 78;
    localparam int Q_SLOW = 312;

    // [31:24] op (0 write, 1 read), [23:16] device address, [15:8] pointer, [7:0] data
    localparam logic [31:0] VEC [6] = '{
        32'h00_42_02_A5,
        32'h01_42_02_00,
        32'h00_42_07_3C,
        32'h01_42_07_00,
        32'h00_43_00_77,
        32'h01_42_00_00
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [63:0] regs;

    int n_chk = 0;
    int n_fail = 0;
    int q = Q_FAST;
    logic [7:0] model [8];

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regfile_slave u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe_o(sda_oe),
        .regs_o  (regs)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; w(q);
        scl_m = 1'b1; w(q);
        sda_m = 1'b0; w(q);
        scl_m = 1'b0; w(q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(q);
        scl_m = 1'b1; w(q);
        sda_m = 1'b1; w(2*q);
    endtask

    // g=1: short SCL pulse while low; g=2: short SDA low pulse while SCL high
    task automatic send_bit(input logic b, input int g);
        sda_m = b; w(q);
        scl_m = 1'b1;
        if (g == 2) begin
            w(q); sda_m = 1'b0; w(2); sda_m = b; w(q-2);
        end else begin
            w(2*q);
        end
        scl_m = 1'b0;
        if (g == 1) begin
            w(q/2); scl_m = 1'b1; w(2); scl_m = 1'b0; w(q - q/2 - 2);
        end else begin
            w(q);
        end
    endtask

    task automatic recv_bit(output logic b, output logic be);
        sda_m = 1'b1; w(q);
        scl_m = 1'b1; w(2);
        be = sda_line; w(2*q-3);
        b = sda_line; w(1);
        scl_m = 1'b0; w(q);
    endtask

    task automatic send_byte(input logic [7:0] d, input int gbit, input int gkind, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(d[i], (i == gbit) ? gkind : 0);
        recv_bit(x, ack);
        ack = ~x;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] d);
        logic [7:0] e;
        for (int i = 7; i >= 0; i--) recv_bit(d[i], e[i]);
        // R10: the bit seen just after SCL rise equals the one before SCL fall
        chk("R10", e, d);
        send_bit(~master_ack, 0);
    endtask

    task automatic do_write(input logic [6:0] dev, input logic [7:0] p, input logic [7:0] d);
        logic a;
        bus_start();
        send_byte({dev, 1'b0}, -1, 0, a);
        chk("R1", a, dev == DEV);
        if (a) begin
            send_byte(p, -1, 0, a);
            chk("R4 ptr ack", a, 1'b1);
            send_byte(d, -1, 0, a);
            chk("R4 data ack", a, 1'b1);
            if (p < 8) model[p[2:0]] = d;
        end
        bus_stop();
        w(20);
        chk((p < 8) ? "R4 stored" : "R9 discarded", regs, model_flat());
    endtask

    task automatic do_read(input logic [6:0] dev, input logic [7:0] p);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({dev, 1'b0}, -1, 0, a);
        chk("R1", a, 1'b1);
        send_byte(p, -1, 0, a);
        chk("R5 ptr ack", a, 1'b1);
        bus_start();
        send_byte({dev, 1'b1}, -1, 0, a);
        chk("R8 read addr ack after Sr", a, 1'b1);
        recv_byte(1'b0, d);
        chk((p < 8) ? "R5 read data" : "R9 read zero", d, (p < 8) ? model[p[2:0]] : 8'h00);
        w(20);
        chk("R6 released after NACK", sda_oe, 1'b0);
        bus_stop();
        w(20);
        chk("R6 idle after STOP", sda_oe, 1'b0);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        w(10);
        rst_n = 1'b1;
        w(20);
        chk("R3 regs reset", regs, 64'h0);
        chk("R3 sda released", sda_oe, 1'b0);

        // table walk at 400 kbit/s
        for (int v = 0; v < 6; v++) begin
            if (VEC[v][31:24] == 8'h00)
                do_write(VEC[v][22:16], VEC[v][15:8], VEC[v][7:0]);
            else
                do_read(VEC[v][22:16], VEC[v][15:8]);
        end

        // R7: two data bytes in one write land in one register
        bus_start();
        send_byte({DEV, 1'b0}, -1, 0, a);
        send_byte(8'h04, -1, 0, a);
        send_byte(8'h11, -1, 0, a);
        send_byte(8'h22, -1, 0, a);
        chk("R7 second byte ack", a, 1'b1);
        bus_stop();
        w(20);
        model[4] = 8'h22;
        chk("R7 no increment on write", regs, model_flat());

        // R2: general call not acked, nothing changes
        bus_start();
        send_byte(8'h00, -1, 0, a);
        chk("R2 general call nack", a, 1'b0);
        bus_stop();
        w(20);
        chk("R2 regs unchanged", regs, model_flat());

        // R1: 10-bit header not acked
        bus_start();
        send_byte(8'hF0, -1, 0, a);
        chk("R1 10-bit header nack", a, 1'b0);
        bus_stop();
        w(20);

        // R8/R12: direct read at 100 kbit/s uses the retained pointer (4)
        q = Q_SLOW;
        bus_start();
        send_byte({DEV, 1'b1}, -1, 0, a);
        chk("R12 slow addr ack", a, 1'b1);
        recv_byte(1'b0, d);
        chk("R8 retained pointer read", d, 8'h22);
        bus_stop();
        q = Q_FAST;
        w(20);

        // R7: master ACK repeats the same register on read
        bus_start();
        send_byte({DEV, 1'b0}, -1, 0, a);
        send_byte(8'h02, -1, 0, a);
        bus_start();
        send_byte({DEV, 1'b1}, -1, 0, a);
        recv_byte(1'b1, d);
        chk("R7 first read byte", d, 8'hA5);
        recv_byte(1'b0, d);
        chk("R7 repeated read byte", d, 8'hA5);
        bus_stop();
        w(20);
        chk("R6 idle after read", sda_oe, 1'b0);

        // R11: SCL glitch in the address byte, SDA glitch in the data byte
        bus_start();
        send_byte({DEV, 1'b0}, 6, 1, a);
        chk("R11 scl glitch ignored", a, 1'b1);
        send_byte(8'h06, -1, 0, a);
        send_byte(8'hFF, 3, 2, a);
        chk("R11 sda glitch ignored", a, 1'b1);
        bus_stop();
        w(20);
        model[6] = 8'hFF;
        chk("R11 data stored", regs, model_flat());

        // R9: out-of-range pointer
        do_write(DEV, 8'h09, 8'hEE);
        do_read(DEV, 8'h09);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule